// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Bridge

This block connects a processor-side request port to an external 8-bit bus of the kind used by small microcontroller-family peripherals. On that bus the low eight address bits and the eight data bits share one set of pins. A single select input starts a transfer. The bridge then runs one or more byte cycles. Each byte cycle has an address phase, which ends with a pulse on the address latch enable so that an external latch can hold the low address. A data phase follows, with an active-low read or write strobe.

Processor transfers may be one byte, a word (two bytes) or a long word (four bytes). Wider transfers are split into byte cycles at consecutive byte addresses, and the most significant byte goes first. For a read, the bytes are collected into one result. The processor sees a single acknowledge pulse after the final byte cycle. The shared pins are split into an output value, an output enable and an input value, so that the pad ring can build the bidirectional buffer.

Top module: `muxbus_bridge`

## Requirements
- R1: While reset is high and in the first cycle after it, `bus_ale` is 0, `bus_rd_n` and `bus_wr_n` are 1, `bus_ad_oe` is 0, `bus_cs_n` is 1 and `cpu_ack` is 0. A reset during a transfer releases every strobe and pin driver after the next clock edge.
- R2: While `bus_ale` is high, the shared pins are driven (`bus_ad_oe`=1) with bits 7:0 of the current byte address, and `bus_addr_hi` carries the bits above bit 7. No strobe is active at the same time.
- R3: While `bus_rd_n` is low, the shared pins are released (`bus_ad_oe`=0).
- R4: While `bus_wr_n` is low, the shared pins are driven with the byte being written, and that byte is held steady.
- R5: `cpu_size` 2'b00 gives 1 byte cycle, 2'b01 gives 2 byte cycles, and 2'b10 or 2'b11 gives 4 byte cycles. The byte addresses are `cpu_addr`, `cpu_addr`+1, and so on, with the carry running through the full address width.
- R6: Byte order is most significant first. The byte at `cpu_addr` is bits [8n-1:8n-8] of the n-byte value. For writes, the value is the low 8n bits of `cpu_wdata`. For reads, it is the low 8n bits of `cpu_rdata`.
- R7: `cpu_ack` is high for exactly one cycle. It rises n*(4+ALE_CYC+STB_CYC)+1 clock edges after the request, counting the edge that accepts `cpu_sel` as the first.
- R8: When `cpu_ack` is high, `cpu_rdata` holds the bytes read, with the bits above 8n set to zero.
- R9: `bus_rd_n` and `bus_wr_n` are never low together.
- R10: `cpu_sel` is accepted only when the bridge is idle. A select raised during a transfer is ignored and causes no extra bus cycle.
- R11: Each latch enable pulse lasts exactly ALE_CYC cycles, and each read or write strobe lasts exactly STB_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Region select; starts a transfer when the bridge is idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 00 byte, 01 word, 10/11 long |
| cpu_addr | input | ADDR_W | Byte address of the first byte |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_ack | output | 1 | One-cycle transfer completion |
| cpu_rdata | output | 32 | Assembled read data, right-aligned |
| bus_ad_out | output | 8 | Value driven on the shared address/data pins |
| bus_ad_oe | output | 1 | Drive enable for the shared pins |
| bus_ad_in | input | 8 | Value seen on the shared pins |
| bus_addr_hi | output | ADDR_W-8 | Upper address bits of the current byte |
| bus_ale | output | 1 | Address latch enable, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_cs_n | output | 1 | External select, low while a transfer runs |

## Verification
The bench builds the bridge with ADDR_W=16, ALE_CYC=2 and STB_CYC=3. Because neither phase length is 1, an off-by-one in the phase counters shows up both in the measured pulse widths and in the acknowledge latency of 9 cycles per byte. A word write at 0x00FF crosses into 0x0100. This exposes the carry into `bus_addr_hi` and the wrap of the bench's byte-wide device model. The bench also covers an unaligned long read, the alias size code 2'b11, a select raised during a transfer, and a reset issued while a write strobe is active.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

    localparam int WORD_W  = 32;
    localparam int LANE_W  = 8;
    localparam int LANES   = WORD_W / LANE_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_LALT = 2'b11
    } size_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ALE,
        PH_HOLD,
        PH_TURN,
        PH_STRB,
        PH_REC,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic       we;
        logic [2:0] nbytes;
    } xfer_t;

    function automatic logic [2:0] byte_count(input size_e sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] align_msb(input logic [WORD_W-1:0] d,
                                                    input logic [2:0] n);
        case (n)
            3'd1:    return {d[7:0], 24'h0};
            3'd2:    return {d[15:0], 16'h0};
            default: return d;
        endcase
    endfunction

    function automatic logic drives_addr(input phase_e ph);
        return (ph == PH_ADDR) || (ph == PH_ALE) || (ph == PH_HOLD);
    endfunction

    function automatic logic in_data(input phase_e ph);
        return (ph == PH_TURN) || (ph == PH_STRB) || (ph == PH_REC);
    endfunction

endpackage

// File: rtl/muxbus_seq.sv
module muxbus_seq
    import muxbus_pkg::*;
#(
    parameter int ALE_CYC = 1,
    parameter int STB_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [2:0] nbytes,
    output phase_e     phase,
    output logic       step,
    output logic       strobe_last,
    output logic       done
);
    localparam int CMAX  = (ALE_CYC > STB_CYC) ? ALE_CYC : STB_CYC;
    localparam int CNT_W = $clog2(CMAX + 1);
    localparam logic [CNT_W-1:0] ALE_LAST = CNT_W'(ALE_CYC - 1);
    localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STB_CYC - 1);

    phase_e           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       idx_q;
    logic             last_byte;

    assign last_byte = ({1'b0, idx_q} == (nbytes - 3'd1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            idx_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        ph_q  <= PH_ADDR;
                        idx_q <= '0;
                    end
                end
                PH_ADDR: begin
                    ph_q  <= PH_ALE;
                    cnt_q <= '0;
                end
                PH_ALE: begin
                    if (cnt_q == ALE_LAST) ph_q <= PH_HOLD;
                    else                   cnt_q <= cnt_q + 1'b1;
                end
                PH_HOLD: ph_q <= PH_TURN;
                PH_TURN: begin
                    ph_q  <= PH_STRB;
                    cnt_q <= '0;
                end
                PH_STRB: begin
                    if (cnt_q == STB_LAST) ph_q <= PH_REC;
                    else                   cnt_q <= cnt_q + 1'b1;
                end
                PH_REC: begin
                    if (last_byte) begin
                        ph_q <= PH_DONE;
                    end else begin
                        ph_q  <= PH_ADDR;
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign phase       = ph_q;
    assign step        = (ph_q == PH_REC) && !last_byte;
    assign strobe_last = (ph_q == PH_STRB) && (cnt_q == STB_LAST);
    assign done        = (ph_q == PH_DONE);

endmodule

// File: rtl/muxbus_addr.sv
module muxbus_addr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst)       addr_q <= '0;
        else if (load) addr_q <= load_addr;
        else if (step) addr_q <= addr_q + 1'b1;
    end

    assign addr = addr_q;

endmodule

// File: rtl/muxbus_lane.sv
module muxbus_lane
    import muxbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] wdata,
    input  logic [2:0]        nbytes,
    input  logic              step,
    input  logic              sample,
    input  logic [LANE_W-1:0] rd_byte,
    output logic [LANE_W-1:0] wr_byte,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] wsh_q;
    logic [WORD_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wsh_q <= '0;
            acc_q <= '0;
        end else begin
            if (load) begin
                wsh_q <= align_msb(wdata, nbytes);
                acc_q <= '0;
            end else begin
                if (step)   wsh_q <= {wsh_q[WORD_W-LANE_W-1:0], {LANE_W{1'b0}}};
                if (sample) acc_q <= {acc_q[WORD_W-LANE_W-1:0], rd_byte};
            end
        end
    end

    assign wr_byte = wsh_q[WORD_W-1 -: LANE_W];
    assign rd_word = acc_q;

endmodule

// File: rtl/muxbus_bridge.sv
module muxbus_bridge
    import muxbus_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int ALE_CYC = 1,
    parameter int STB_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic              cpu_ack,
    output logic [31:0]       cpu_rdata,
    output logic [7:0]        bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [7:0]        bus_ad_in,
    output logic [ADDR_W-9:0] bus_addr_hi,
    output logic              bus_ale,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_cs_n
);
    phase_e            phase;
    logic              start, step, strobe_last, done;
    xfer_t             xf_q;
    logic [2:0]        req_n;
    logic [ADDR_W-1:0] cur_addr;
    logic [7:0]        wr_byte;
    logic              addr_drv, data_drv;

    assign start = cpu_sel && (phase == PH_IDLE);
    assign req_n = byte_count(size_e'(cpu_size));

    always_ff @(posedge clk) begin
        if (rst)        xf_q <= '{we: 1'b0, nbytes: 3'd1};
        else if (start) xf_q <= '{we: cpu_we, nbytes: req_n};
    end

    muxbus_seq #(
        .ALE_CYC (ALE_CYC),
        .STB_CYC (STB_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .nbytes      (xf_q.nbytes),
        .phase       (phase),
        .step        (step),
        .strobe_last (strobe_last),
        .done        (done)
    );

    muxbus_addr #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .load_addr (cpu_addr),
        .step      (step),
        .addr      (cur_addr)
    );

    muxbus_lane u_lane (
        .clk     (clk),
        .rst     (rst),
        .load    (start),
        .wdata   (cpu_wdata),
        .nbytes  (req_n),
        .step    (step),
        .sample  (strobe_last && !xf_q.we),
        .rd_byte (bus_ad_in),
        .wr_byte (wr_byte),
        .rd_word (cpu_rdata)
    );

    assign addr_drv    = drives_addr(phase);
    assign data_drv    = in_data(phase) && xf_q.we;
    assign bus_ad_oe   = addr_drv || data_drv;
    assign bus_ad_out  = addr_drv ? cur_addr[7:0] : (data_drv ? wr_byte : 8'h00);
    assign bus_addr_hi = cur_addr[ADDR_W-1:8];
    assign bus_ale     = (phase == PH_ALE);
    assign bus_rd_n    = !((phase == PH_STRB) && !xf_q.we);
    assign bus_wr_n    = !((phase == PH_STRB) &&  xf_q.we);
    assign bus_cs_n    = (phase == PH_IDLE) || (phase == PH_DONE);
    assign cpu_ack     = done;

endmodule

// File: rtl/muxbus_bridge_chk.sv
module muxbus_bridge_chk (
    input logic       clk,
    input logic       rst,
    input logic       ale,
    input logic       rd_n,
    input logic       wr_n,
    input logic       ad_oe,
    input logic [7:0] ad_out,
    input logic       ack
);
    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    a_r3_read_release: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    a_r4_write_drive: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);

    a_r4_write_stable: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && $past(!wr_n) && !$past(rst)) |-> $stable(ad_out));

    a_r2_ale_addr: assert property (@(posedge clk) disable iff (rst)
        ale |-> (ad_oe && rd_n && wr_n));

    a_r7_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    a_r1_reset_release: assert property (@(posedge clk)
        $past(rst) |-> (rd_n && wr_n && !ale && !ad_oe && !ack));

endmodule

bind muxbus_bridge muxbus_bridge_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .ale    (bus_ale),
    .rd_n   (bus_rd_n),
    .wr_n   (bus_wr_n),
    .ad_oe  (bus_ad_oe),
    .ad_out (bus_ad_out),
    .ack    (cpu_ack)
);

// File: tb/muxbus_bridge_test.sv
module muxbus_bridge_test;
    localparam int ALE = 2;
    localparam int STB = 3;
    localparam int BC  = 4 + ALE + STB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'b00;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic [7:0]  bus_ad_out, bus_ad_in;
    logic        bus_ad_oe, bus_ale, bus_rd_n, bus_wr_n, bus_cs_n;
    logic [7:0]  bus_addr_hi;

    always #4 clk = ~clk;

    muxbus_bridge #(.ADDR_W(16), .ALE_CYC(ALE), .STB_CYC(STB)) uut (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .bus_ad_out(bus_ad_out),
        .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in), .bus_addr_hi(bus_addr_hi),
        .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_cs_n(bus_cs_n)
    );

    int compared = 0, mismatched = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // external device model
    logic [7:0]  mem [0:255];
    logic [15:0] lat = '0;
    logic [15:0] logv [0:7];
    int nlog = 0, ale_len = 0, strb_len = 0;
    int ale_err = 0, strb_err = 0, r2_err = 0, r3_err = 0, r4_err = 0, r9_err = 0;
    int ale_seen = 0, strb_seen = 0;
    logic [7:0] wbyte = '0;
    bit wpend = 0;

    assign bus_ad_in = mem[lat[7:0]];

    always @(negedge clk) begin
        if (rst) begin
            ale_len = 0; strb_len = 0; wpend = 0;
        end else begin
            if (bus_ale) begin
                if (ale_len == 0 && nlog < 8) begin
                    logv[nlog] = {bus_addr_hi, bus_ad_out};
                    nlog++;
                end
                lat = {bus_addr_hi, bus_ad_out};
                ale_len++;
                if (!bus_ad_oe || !bus_rd_n || !bus_wr_n) r2_err++;
            end else if (ale_len != 0) begin
                if (ale_len != ALE) ale_err++;
                ale_seen++;
                ale_len = 0;
            end
            if (!bus_rd_n && !bus_wr_n) r9_err++;
            if (!bus_rd_n || !bus_wr_n) begin
                strb_len++;
                if (!bus_rd_n && bus_ad_oe) r3_err++;
                if (!bus_wr_n) begin
                    if (!bus_ad_oe) r4_err++;
                    if (wpend && bus_ad_out != wbyte) r4_err++;
                    wbyte = bus_ad_out;
                    wpend = 1;
                end
            end else if (strb_len != 0) begin
                if (strb_len != STB) strb_err++;
                strb_seen++;
                strb_len = 0;
                if (wpend) mem[lat[7:0]] = wbyte;
                wpend = 0;
            end
        end
    end

    bit finished = 0;
    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!finished) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic do_xfer(input logic we, input logic [1:0] sz, input logic [15:0] a,
                           input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        cpu_sel = 1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
        nlog = 0; cyc = 0;
        do begin
            @(posedge clk); cyc++;
            @(negedge clk); cpu_sel = 0;
        end while (!cpu_ack && cyc < 2000);
        rd = cpu_rdata;
        @(negedge clk);
        check(!cpu_ack, "R7 ack width", {31'd0, cpu_ack}, 32'd0);
    endtask

    // {we, size, addr, wdata}
    localparam logic [50:0] VEC [0:7] = '{
        {1'b1, 2'b10, 16'h0010, 32'hA1B2C3D4},
        {1'b0, 2'b10, 16'h0010, 32'h0},
        {1'b1, 2'b01, 16'h00FF, 32'hFFFF5A6B},
        {1'b0, 2'b01, 16'h00FF, 32'h0},
        {1'b1, 2'b00, 16'h0042, 32'h123456E7},
        {1'b0, 2'b00, 16'h0042, 32'h0},
        {1'b0, 2'b10, 16'h0011, 32'h0},
        {1'b0, 2'b11, 16'h0020, 32'h0}
    };

    initial begin
        logic [31:0] rd, exp;
        int cyc, n;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);

        // R1: reset state
        repeat (3) @(negedge clk);
        check(bus_ale == 0 && bus_rd_n && bus_wr_n && !bus_ad_oe && bus_cs_n && !cpu_ack,
              "R1 in reset", {27'd0, bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, cpu_ack}, 32'h0C);
        rst = 0;
        @(negedge clk);
        check(bus_ale == 0 && bus_rd_n && bus_wr_n && !bus_ad_oe && bus_cs_n && !cpu_ack,
              "R1 after reset", {27'd0, bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, cpu_ack}, 32'h0C);

        foreach (VEC[v]) begin
            logic        we;
            logic [1:0]  sz;
            logic [15:0] a;
            logic [31:0] wd;
            {we, sz, a, wd} = VEC[v];
            n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
            exp = 0;
            for (int k = 0; k < n; k++) exp = (exp << 8) | 32'(mem[8'(a + 16'(k))]);
            do_xfer(we, sz, a, wd, rd, cyc);
            check(cyc == n * BC + 1, "R7 latency", cyc, n * BC + 1);
            check(nlog == n, "R5 byte cycles", nlog, n);
            for (int k = 0; k < n && k < nlog; k++)
                check(logv[k] == a + 16'(k), "R5 R2 byte address", {16'd0, logv[k]},
                      {16'd0, a + 16'(k)});
            if (we) begin
                for (int k = 0; k < n; k++)
                    check(mem[8'(a + 16'(k))] == wd[8*(n-1-k) +: 8], "R6 R4 written byte",
                          {24'd0, mem[8'(a + 16'(k))]}, {24'd0, wd[8*(n-1-k) +: 8]});
            end else begin
                check(rd == exp, "R8 R6 read data", rd, exp);
            end
        end

        check(ale_err == 0 && ale_seen > 0, "R11 latch pulse width", ale_err, 0);
        check(strb_err == 0 && strb_seen > 0, "R11 strobe width", strb_err, 0);
        check(r2_err == 0, "R2 address phase drive", r2_err, 0);
        check(r3_err == 0, "R3 read release", r3_err, 0);
        check(r4_err == 0, "R4 write drive", r4_err, 0);
        check(r9_err == 0, "R9 strobe exclusion", r9_err, 0);

        // R10: select during a busy byte read is ignored
        @(negedge clk);
        cpu_sel = 1; cpu_we = 0; cpu_size = 2'b00; cpu_addr = 16'h0033; nlog = 0; cyc = 0;
        exp = {24'd0, mem[8'h33]};
        do begin
            @(posedge clk); cyc++;
            @(negedge clk);
            cpu_sel = (cyc == 4);
            cpu_we  = (cyc == 4);
        end while (!cpu_ack && cyc < 2000);
        check(cyc == BC + 1, "R10 latency unchanged", cyc, BC + 1);
        check(cpu_rdata == exp, "R10 read data", cpu_rdata, exp);
        repeat (30) @(negedge clk);
        check(nlog == 1, "R10 no extra cycle", nlog, 1);
        check(bus_cs_n == 1'b1, "R10 idle select", {31'd0, bus_cs_n}, 1);

        // R1: reset during a write strobe
        @(negedge clk);
        cpu_sel = 1; cpu_we = 1; cpu_size = 2'b10; cpu_addr = 16'h0080; cpu_wdata = 32'h01020304;
        @(negedge clk); cpu_sel = 0;
        for (int k = 0; k < 100 && bus_wr_n; k++) @(negedge clk);
        check(!bus_wr_n, "R4 write strobe reached", {31'd0, bus_wr_n}, 0);
        rst = 1;
        @(negedge clk);
        check(bus_wr_n && bus_rd_n && !bus_ale && !bus_ad_oe && !cpu_ack,
              "R1 reset mid transfer", {27'd0, bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, cpu_ack},
              32'h0C);
        rst = 0;
        repeat (5) @(negedge clk);
        check(bus_cs_n && bus_wr_n, "R1 idle after reset", {30'd0, bus_cs_n, bus_wr_n}, 32'h3);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule